// File: doc/BRIEF.md
# Split-Register 10-bit PWM Generator

This block produces a pulse-width-modulated output whose high time is set by a 10-bit duty value, while the period is set by an 8-bit register. Software writes the duty value in two parts. One port writes the upper eight bits and a separate port writes the two lower bits. An 8-bit timer is extended below by a 2-bit sub-count, so one period is split into four times as many compare steps as the timer alone provides. A prescaler in front of the counters divides the input clock by 1, 4 or 16.

Each period starts with the output high. The output drops once the 10-bit running count `{timer, sub-count}` reaches the active duty value. Duty writes go into holding registers. They are copied into the active compare value only when the timer wraps from the period value back to zero, so every period runs with one consistent duty value. The period and prescale settings take effect as soon as they are written. With the period register at 255 and divide-by-16 on a 4 MHz clock, one period lasts 16384 input clocks, which is 4.096 ms.

Top module: `pwm10_split`

## Requirements
- R1: The active duty value is the 8-bit upper register in bits [9:2] followed by the 2-bit low field in bits [1:0]. With the low field at zero, each step of the upper register moves the high time by 4 prescaled clocks.
- R2: When the active duty value D is below 4×(P+1), the output is high for exactly D×N input clocks in each period, where N is the prescale divisor.
- R3: One period lasts (P+1)×4×N input clocks, where P is the period register.
- R4: Prescale select code 0 gives N=1, code 1 gives N=4, code 2 gives N=16 and code 3 also gives N=16.
- R5: A duty write does not change the period that is running. The new value applies from the next wrap of the timer from P to zero.
- R6: An active duty value greater than or equal to 4×(P+1) holds the output high for the whole period.
- R7: An active duty value of zero holds the output low.
- R8: While reset is asserted, and after its release until the first duty write has been latched, the output is low. Reset clears the timer, the sub-count and all registers.
- R9: When the duty value is non-zero, the output is high at the first count of every period, so rising edges mark period starts.
- R10: The duty registers change only when written. Writing the period alone leaves the high time unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_period | input | 1 | Write strobe for the period register |
| period_din | input | 8 | New period register value |
| wr_duty_hi | input | 1 | Write strobe for the duty upper byte |
| duty_hi_din | input | 8 | New duty bits [9:2] |
| wr_duty_lo | input | 1 | Write strobe for the duty low field |
| duty_lo_din | input | 2 | New duty bits [1:0] |
| wr_presc | input | 1 | Write strobe for the prescale select |
| presc_din | input | 2 | Prescale select code |
| pwm_out | output | 1 | PWM output |

## Verification
The embedded properties assume that every input is a known level at each clock edge once reset has been applied. The full-period-high property only claims anything while the timer sits at or below the period register, because lowering the period under a running timer leaves a single wrap-around period. The bench drives every input on the falling clock edge and holds strobes for exactly one cycle. It judges high and period lengths only on periods that start after the second rising output edge following a configuration change, so a period that was partly run under old settings is never measured.

// File: rtl/pwm10_pkg.sv
// pwm10_pkg: shared widths and the prescale decode for the split-register PWM.
// Assumes the prescale divisor grows by a constant power of two per select code
// and saturates at MAX_CODE.
package pwm10_pkg;

    localparam int TMR_W     = 8;                    // period timer width
    localparam int SUB_W     = 2;                    // sub-count below the timer
    localparam int SEL_W     = 2;                    // prescale select width
    localparam int DIV_SHIFT = 2;                    // log2 of divisor step per code
    localparam int MAX_CODE  = 2;                    // codes above this saturate
    localparam int PCNT_W    = DIV_SHIFT * MAX_CODE; // prescale counter width
    localparam int DUTY_W    = TMR_W + SUB_W;        // full compare width

    // Terminal count of the prescale counter for a given select code.
    function automatic logic [PCNT_W-1:0] presc_last(input logic [SEL_W-1:0] code);
        int eff;
        eff = (int'(code) > MAX_CODE) ? MAX_CODE : int'(code);
        return PCNT_W'((1 << (DIV_SHIFT * eff)) - 1);
    endfunction

endpackage

// File: rtl/pwm10_prescaler.sv
// pwm10_prescaler: divides the input clock by the divisor picked by sel and
// emits a one-cycle tick at the end of each divided interval.
// Assumes sel may change at any time; a counter already past the new terminal
// count ends its interval on the next cycle.
module pwm10_prescaler
    import pwm10_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int CW = PCNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sel,
    output logic          tick
);

    logic [CW-1:0] pcnt;
    logic [CW-1:0] last;

    // Decode the terminal count for the current select code.
    always_comb begin
        last = CW'(presc_last(SEL_W'(sel)));
        tick = (pcnt >= last);
    end

    // Count input clocks and restart after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)     pcnt <= '0;
        else if (tick)  pcnt <= '0;
        else            pcnt <= pcnt + 1'b1;
    end

    // R4
    prescale_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pcnt == '0));

    // R4
    prescale_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && $stable(sel)) |=> (pcnt == $past(pcnt) + 1'b1));

endmodule

// File: rtl/pwm10_timebase.sv
// pwm10_timebase: the 8-bit period timer with a 2-bit sub-count below it.
// The sub-count advances on each prescale tick and the timer advances when the
// sub-count wraps. The timer returns to zero after reaching the period value,
// or at once if the period was lowered below it.
module pwm10_timebase #(
    parameter int TW = 8,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [TW-1:0] period,
    output logic [TW-1:0] timer,
    output logic [SW-1:0] sub,
    output logic          rollover
);

    localparam logic [SW-1:0] SUB_LAST = '1;

    logic sub_wrap;
    logic rst_seen;

    // Flag the cycle where the timer wraps back to the period start.
    always_comb begin
        sub_wrap = tick && (sub == SUB_LAST);
        rollover = sub_wrap && (timer >= period);
    end

    // Advance the sub-count on every prescale tick.
    always_ff @(posedge clk) begin
        if (!rst_n)     sub <= '0;
        else if (tick)  sub <= sub + 1'b1;
    end

    // Advance the timer on each sub-count wrap and clear it at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n)         timer <= '0;
        else if (rollover)  timer <= '0;
        else if (sub_wrap)  timer <= timer + 1'b1;
    end

    // Remember that at least one active clock has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_seen <= 1'b0;
        else        rst_seen <= 1'b1;
    end

    // R8
    counts_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_seen |-> (timer == '0 && sub == '0));

    // R3
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rollover |=> (timer == '0 && sub == '0));

    // R3
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(timer) && $stable(sub)));

endmodule

// File: rtl/pwm10_regfile.sv
// pwm10_regfile: the written configuration and the active duty latch.
// Period and prescale select apply on write. The duty upper byte and low field
// are holding registers. Their concatenation is copied into the active duty
// value only on a timer rollover.
module pwm10_regfile #(
    parameter int TW = 8,
    parameter int SW = 2,
    parameter int PW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_period,
    input  logic [TW-1:0]    period_din,
    input  logic             wr_duty_hi,
    input  logic [TW-1:0]    duty_hi_din,
    input  logic             wr_duty_lo,
    input  logic [SW-1:0]    duty_lo_din,
    input  logic             wr_presc,
    input  logic [PW-1:0]    presc_din,
    input  logic             rollover,
    output logic [TW-1:0]    period_q,
    output logic [PW-1:0]    presc_q,
    output logic [TW+SW-1:0] duty_act
);

    logic [TW-1:0] duty_hi_q;
    logic [SW-1:0] duty_lo_q;

    // Store the period register on write.
    always_ff @(posedge clk) begin
        if (!rst_n)         period_q <= '0;
        else if (wr_period) period_q <= period_din;
    end

    // Store the prescale select on write.
    always_ff @(posedge clk) begin
        if (!rst_n)        presc_q <= '0;
        else if (wr_presc) presc_q <= presc_din;
    end

    // Store the duty upper byte on write; it never changes by itself.
    always_ff @(posedge clk) begin
        if (!rst_n)          duty_hi_q <= '0;
        else if (wr_duty_hi) duty_hi_q <= duty_hi_din;
    end

    // Store the duty low field on write; it never changes by itself.
    always_ff @(posedge clk) begin
        if (!rst_n)          duty_lo_q <= '0;
        else if (wr_duty_lo) duty_lo_q <= duty_lo_din;
    end

    // Latch the combined duty value at the start of each period.
    always_ff @(posedge clk) begin
        if (!rst_n)        duty_act <= '0;
        else if (rollover) duty_act <= {duty_hi_q, duty_lo_q};
    end

    // R10
    hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_duty_hi |=> $stable(duty_hi_q));

    // R10
    lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_duty_lo |=> $stable(duty_lo_q));

    // R5
    act_only_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rollover |=> $stable(duty_act));

    // R1
    act_from_parts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rollover && !wr_duty_hi && !wr_duty_lo) |=>
            (duty_act[TW+SW-1:SW] == duty_hi_q && duty_act[SW-1:0] == duty_lo_q));

endmodule

// File: rtl/pwm10_split.sv
// pwm10_split: PWM generator with an 8-bit period, selectable prescale and a
// 10-bit duty value written as an upper byte and a low field.
// Assumes synchronous active-low reset and one-cycle write strobes. The output
// is high while the running count {timer, sub} is below the active duty value.
module pwm10_split
    import pwm10_pkg::*;
#(
    parameter int TW = TMR_W,
    parameter int SW = SUB_W,
    parameter int PW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_period,
    input  logic [TW-1:0] period_din,
    input  logic          wr_duty_hi,
    input  logic [TW-1:0] duty_hi_din,
    input  logic          wr_duty_lo,
    input  logic [SW-1:0] duty_lo_din,
    input  logic          wr_presc,
    input  logic [PW-1:0] presc_din,
    output logic          pwm_out
);

    localparam int CW = TW + SW;

    logic          tick;
    logic          rollover;
    logic [TW-1:0] timer;
    logic [SW-1:0] sub;
    logic [TW-1:0] period_q;
    logic [PW-1:0] presc_q;
    logic [CW-1:0] duty_act;
    logic [CW-1:0] run_cnt;
    logic [CW:0]   full_cnt;

    pwm10_prescaler #(.SW(PW), .CW(PCNT_W)) i_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (presc_q),
        .tick  (tick)
    );

    pwm10_timebase #(.TW(TW), .SW(SW)) i_tbase (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .period   (period_q),
        .timer    (timer),
        .sub      (sub),
        .rollover (rollover)
    );

    pwm10_regfile #(.TW(TW), .SW(SW), .PW(PW)) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_period   (wr_period),
        .period_din  (period_din),
        .wr_duty_hi  (wr_duty_hi),
        .duty_hi_din (duty_hi_din),
        .wr_duty_lo  (wr_duty_lo),
        .duty_lo_din (duty_lo_din),
        .wr_presc    (wr_presc),
        .presc_din   (presc_din),
        .rollover    (rollover),
        .period_q    (period_q),
        .presc_q     (presc_q),
        .duty_act    (duty_act)
    );

    // Compare the fine-resolution running count with the active duty value.
    always_comb begin
        run_cnt  = {timer, sub};
        full_cnt = {1'b0, period_q, {SW{1'b1}}} + 1'b1;
        pwm_out  = (run_cnt < duty_act);
    end

    // R7
    zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_act == '0) |-> !pwm_out);

    // R9
    period_start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timer == '0 && sub == '0 && duty_act != '0) |-> pwm_out);

    // R6
    full_duty_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, duty_act} >= full_cnt && timer <= period_q) |-> pwm_out);

    // R2
    drop_at_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == duty_act) |-> !pwm_out);

endmodule

// File: tb/test_pwm10_split.sv
module test_pwm10_split;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_period = 1'b0;
    logic [7:0] period_din = '0;
    logic       wr_duty_hi = 1'b0;
    logic [7:0] duty_hi_din = '0;
    logic       wr_duty_lo = 1'b0;
    logic [1:0] duty_lo_din = '0;
    logic       wr_presc = 1'b0;
    logic [1:0] presc_din = '0;
    logic       pwm_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk; // 250 MHz

    pwm10_split i_pwm10_split (
        .clk(clk), .rst_n(rst_n),
        .wr_period(wr_period), .period_din(period_din),
        .wr_duty_hi(wr_duty_hi), .duty_hi_din(duty_hi_din),
        .wr_duty_lo(wr_duty_lo), .duty_lo_din(duty_lo_din),
        .wr_presc(wr_presc), .presc_din(presc_din),
        .pwm_out(pwm_out)
    );

    // {sel[2], period[8], hi[8], lo[2], exp_high[16], exp_period[16]}
    localparam int NV = 8;
    localparam logic [51:0] VEC [NV] = '{
        {2'd0, 8'd9,  8'd2,  2'd1, 16'd9,   16'd40},  // R1 R2 R4 code 0
        {2'd0, 8'd9,  8'd1,  2'd0, 16'd4,   16'd40},  // R1 step of 4
        {2'd0, 8'd9,  8'd2,  2'd0, 16'd8,   16'd40},  // R1 step of 4
        {2'd1, 8'd3,  8'd1,  2'd3, 16'd28,  16'd64},  // R4 code 1
        {2'd2, 8'd2,  8'd2,  2'd2, 16'd160, 16'd192}, // R4 code 2
        {2'd3, 8'd1,  8'd0,  2'd1, 16'd16,  16'd128}, // R4 code 3 = 16
        {2'd0, 8'd0,  8'd0,  2'd3, 16'd3,   16'd4},   // R3 smallest period
        {2'd1, 8'd15, 8'd15, 2'd3, 16'd252, 16'd256}  // R2 near full
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_all(input logic [1:0] s, input logic [7:0] p,
                             input logic [7:0] h, input logic [1:0] l);
        @(negedge clk);
        wr_presc = 1'b1; presc_din = s;
        wr_period = 1'b1; period_din = p;
        wr_duty_hi = 1'b1; duty_hi_din = h;
        wr_duty_lo = 1'b1; duty_lo_din = l;
        @(negedge clk);
        wr_presc = 1'b0; wr_period = 1'b0; wr_duty_hi = 1'b0; wr_duty_lo = 1'b0;
    endtask

    // Stop at the negedge where the output is first seen high after being low.
    task automatic wait_rise(output bit ok);
        bit prev;
        ok = 1'b0;
        prev = pwm_out;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (!prev && pwm_out) begin ok = 1'b1; break; end
            prev = pwm_out;
        end
    endtask

    task automatic measure(output int hi_n, output int per_n);
        bit ok;
        wait_rise(ok);
        hi_n = -1; per_n = -1;
        if (ok) begin
            hi_n = 0;
            while (pwm_out && hi_n < 40000) begin hi_n++; @(negedge clk); end
            per_n = hi_n;
            while (!pwm_out && per_n < 40000) begin per_n++; @(negedge clk); end
        end
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) h++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int h, p, h2, p2, hc;
        bit ok;

        // R8: output low during reset and with no duty written afterwards
        repeat (3) @(negedge clk);
        check("R8 low in reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        count_high(200, hc);
        check("R8 low after reset", hc, 0);

        // Table of configurations: R1 R2 R3 R4 R9
        for (int v = 0; v < NV; v++) begin
            write_all(VEC[v][51:50], VEC[v][49:42], VEC[v][41:34], VEC[v][33:32]);
            measure(h, p);
            measure(h, p);
            check($sformatf("R2 high time row %0d", v), h, int'(VEC[v][31:16]));
            check($sformatf("R3 R9 period row %0d", v), p, int'(VEC[v][15:0]));
        end

        // R10: period write alone keeps the duty value
        write_all(2'd0, 8'd9, 8'd2, 2'd1);
        measure(h, p); measure(h, p);
        @(negedge clk);
        wr_period = 1'b1; period_din = 8'd19;
        @(negedge clk);
        wr_period = 1'b0;
        measure(h, p); measure(h, p);
        check("R10 duty kept over period write", h, 9);
        check("R3 new period", p, 80);
        measure(h2, p2);
        check("R10 duty stable across periods", h2, 9);

        // R5: a duty write in mid-period waits for the wrap
        write_all(2'd0, 8'd9, 8'd5, 2'd0);
        measure(h, p); measure(h, p);
        wait_rise(ok);
        h = 1;
        wr_duty_hi = 1'b1; duty_hi_din = 8'd1;
        @(negedge clk);
        wr_duty_hi = 1'b0;
        while (pwm_out && h < 1000) begin h++; @(negedge clk); end
        check("R5 running period unchanged", h, 20);
        measure(h, p);
        check("R5 new duty next period", h, 4);

        // R6: duty equal to and far above the full count
        write_all(2'd0, 8'd9, 8'd10, 2'd0);
        repeat (100) @(negedge clk);
        count_high(120, hc);
        check("R6 duty equal to full count", hc, 120);
        write_all(2'd0, 8'd9, 8'd255, 2'd3);
        repeat (100) @(negedge clk);
        count_high(120, hc);
        check("R6 duty max", hc, 120);

        // R7: zero duty
        write_all(2'd0, 8'd9, 8'd0, 2'd0);
        repeat (100) @(negedge clk);
        count_high(120, hc);
        check("R7 zero duty", hc, 0);

        // R3 R4: largest period with divide-by-16 gives 16384 clocks
        write_all(2'd2, 8'd255, 8'd128, 2'd0);
        measure(h, p); measure(h, p);
        check("R2 half duty full scale", h, 8192);
        check("R3 full scale period", p, 16384);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule